// File: doc/BRIEF.md
# Per-Master Aperture Remap Decoder

This block is the address decoder of a memory bridge that several bus masters share. Every master has its own routing table. The table splits the 4 GB address space into sixteen 256 MB apertures, taken from the top four address bits. For each aperture the table holds two 4-bit fields. One names the slave port that serves the access. The other replaces the top four address bits, so that the access can be relocated inside that slave. The decode is purely combinational. For each master the block returns a slave index, a translated address and a decode-error flag.

Software programs the tables through a flat word-write interface with combinational read-back. A write lands in a staged copy of the table. The staged copy reaches the live decoder only after the value 1 is written to that master's commit register. The live copy is then reloaded as a whole, one cycle later, so a request never meets a half-written table.

Master 0 has a boot register whose mirror bits redirect its lowest aperture to the ROM. A separate address-extension register, with its own staged and live copies and its own commit register, drives a small output field.

Top module: `aperture_remap_decoder`

## Requirements
- R1: The aperture of a request is `req_addr[31:28]`. Aperture a (0 to 7) is read from bits [4a+3:4a] of select/offset word 0. Aperture a (8 to 15) is read from bits [4(a-8)+3:4(a-8)] of word 1.
- R2: The translated address equals the aperture's 4-bit offset field, followed by `req_addr[27:0]` unchanged.
- R3: Slave codes 1 to 10 appear unchanged on the master's `slv_idx` field, with `dec_err` low. Code 0 or any code from 11 to 15 raises `dec_err` and drives `slv_idx` to 0.
- R4: Master m's registers start at byte address 0x20*m. Select word 0 is at +0x00, select word 1 at +0x04, offset word 0 at +0x08, offset word 1 at +0x0C and the commit register at +0x14. Reads return the staged value. The commit register and unmapped addresses read 0.
- R5: A write to a select or offset word leaves the decode unchanged until the value 1 is written to that master's commit register. A commit write of any other value is ignored.
- R6: After a valid commit write on clock edge k, the outputs still show the old table between edges k and k+1. They show the whole new table after edge k+1.
- R7: After reset, both copies hold slave code 1 in every aperture (0x11111111 in both select words) and identity offsets (word 0 = 0x76543210, word 1 = 0xFEDCBA98). Decoding is valid from the first cycle.
- R8: The boot register is at 0x010 and its mirror bits are [1:0], with reset value 01. It takes effect on the edge that writes it. While the mirror bits are nonzero, master 0's aperture 0 decodes to slave 5 (ROM) with offset field 0. While they are zero, the programmed entry applies.
- R9: The extension register is at 0x180, with reset value 1 in both copies, and drives `ext_offset`. A write to it changes only the staged copy. Writing 1 to 0x194 loads the live copy one cycle later, following the same timing as R6.
- R10: A commit to one master changes no other master's decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Combinational read data (staged values) |
| req_addr | input | 384 | Request address per master, master m in bits [32m+31:32m] |
| slv_idx | output | 48 | Selected slave per master, master m in bits [4m+3:4m] |
| xlat_addr | output | 384 | Translated address per master |
| dec_err | output | 12 | Decode error per master |
| ext_offset | output | 4 | Live address-extension value |

## Verification
A stuck or mis-sequenced live copy appears at once on `slv_idx` and `xlat_addr`. It shows either as a decode that moves before its commit or as one that lags past the second edge, and the bench samples both sides of that edge. A corrupted staged copy appears at the next read-back, or at the first decode after the following commit. A wrong field index or a wrong mirror override appears in the same cycle as the request that lands in the affected aperture.

// File: rtl/apr_pkg.sv
package apr_pkg;
   localparam int unsigned CFG_WORD_W   = 32;
   localparam int unsigned GROUP_BYTES  = 32;
   localparam int unsigned GROUP_OFF_W  = 5;
   localparam logic [4:0]  OFF_BOOT     = 5'h10;
   localparam logic [4:0]  OFF_COMMIT   = 5'h14;

   typedef enum logic [3:0] {
      SLV_NONE   = 4'd0,
      SLV_DDR_A  = 4'd1,
      SLV_SRAM   = 4'd2,
      SLV_TUNNEL = 4'd3,
      SLV_EXTBUS = 4'd4,
      SLV_ROM    = 4'd5,
      SLV_PERIPH = 4'd6,
      SLV_DDR_B  = 4'd7,
      SLV_DDR_C  = 4'd8,
      SLV_COHER  = 4'd9,
      SLV_LOCAL  = 4'd10
   } slave_code_e;
endpackage

// File: rtl/remap_table.sv
module remap_table #(
   parameter int unsigned NUM_AP   = 16,
   parameter int unsigned FIELD_W  = 4,
   parameter int unsigned RST_CODE = 1,
   localparam int unsigned TBL_W   = NUM_AP * FIELD_W,
   localparam int unsigned WORDS   = TBL_W / apr_pkg::CFG_WORD_W
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   wr_en,
   input  logic [apr_pkg::GROUP_OFF_W-1:0]        wr_off,
   input  logic [apr_pkg::CFG_WORD_W-1:0]         wdata,
   input  logic [apr_pkg::GROUP_OFF_W-1:0]        rd_off,
   output logic [apr_pkg::CFG_WORD_W-1:0]         rd_data,
   output logic [TBL_W-1:0]                       act_sel,
   output logic [TBL_W-1:0]                       act_ofs
);
   import apr_pkg::*;

   if ((TBL_W % CFG_WORD_W) != 0) begin : g_bad_width
      $error("remap_table: table width must fill whole words");
   end
   if ((2 * WORDS * 4) > int'(OFF_BOOT)) begin : g_bad_map
      $error("remap_table: table words overlap the boot/commit slots");
   end

   logic [TBL_W-1:0] rst_sel, rst_ofs;
   logic [TBL_W-1:0] stg_sel, stg_ofs;
   logic             commit_q;

   for (genvar a = 0; a < NUM_AP; a++) begin : g_rst
      assign rst_sel[a*FIELD_W +: FIELD_W] = FIELD_W'(RST_CODE);
      assign rst_ofs[a*FIELD_W +: FIELD_W] = FIELD_W'(a);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_sel <= rst_sel;
         stg_ofs <= rst_ofs;
      end else if (wr_en) begin
         for (int w = 0; w < int'(WORDS); w++) begin
            if (wr_off == GROUP_OFF_W'(4 * w))
               stg_sel[w*CFG_WORD_W +: CFG_WORD_W] <= wdata;
            if (wr_off == GROUP_OFF_W'(4 * (int'(WORDS) + w)))
               stg_ofs[w*CFG_WORD_W +: CFG_WORD_W] <= wdata;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) commit_q <= 1'b0;
      else        commit_q <= wr_en && (wr_off == OFF_COMMIT) && (wdata == 32'd1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_sel <= rst_sel;
         act_ofs <= rst_ofs;
      end else if (commit_q) begin
         act_sel <= stg_sel;
         act_ofs <= stg_ofs;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int w = 0; w < int'(WORDS); w++) begin
         if (rd_off == GROUP_OFF_W'(4 * w))
            rd_data = stg_sel[w*CFG_WORD_W +: CFG_WORD_W];
         if (rd_off == GROUP_OFF_W'(4 * (int'(WORDS) + w)))
            rd_data = stg_ofs[w*CFG_WORD_W +: CFG_WORD_W];
      end
   end

   AST_LIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_q |=> ($stable(act_sel) && $stable(act_ofs))); // R5
   AST_COMMIT_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
      commit_q |=> (act_sel == $past(stg_sel) && act_ofs == $past(stg_ofs))); // R6
endmodule

// File: rtl/remap_lookup.sv
module remap_lookup #(
   parameter int unsigned NUM_AP    = 16,
   parameter int unsigned FIELD_W   = 4,
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned MAX_CODE  = 10,
   parameter int unsigned BOOT_CODE = 5,
   parameter bit          BOOT_EN   = 1'b0,
   localparam int unsigned TBL_W    = NUM_AP * FIELD_W,
   localparam int unsigned AP_BITS  = $clog2(NUM_AP),
   localparam int unsigned LOW_W    = ADDR_W - AP_BITS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [TBL_W-1:0]   act_sel,
   input  logic [TBL_W-1:0]   act_ofs,
   input  logic               boot_mirror,
   input  logic [ADDR_W-1:0]  req_addr,
   output logic [FIELD_W-1:0] slv_idx,
   output logic [ADDR_W-1:0]  xlat_addr,
   output logic               dec_err
);
   if (FIELD_W != AP_BITS) begin : g_bad_field
      $error("remap_lookup: offset field must replace the aperture bits");
   end
   if (MAX_CODE >= (1 << FIELD_W)) begin : g_bad_code
      $error("remap_lookup: MAX_CODE does not fit the field");
   end

   logic [AP_BITS-1:0] ap;
   logic [FIELD_W-1:0] tbl_code, tbl_ofs, code, ofs;
   logic               mirror_hit;

   assign ap       = req_addr[ADDR_W-1 -: AP_BITS];
   assign tbl_code = act_sel[int'(ap)*FIELD_W +: FIELD_W];
   assign tbl_ofs  = act_ofs[int'(ap)*FIELD_W +: FIELD_W];

   if (BOOT_EN) begin : g_boot
      assign mirror_hit = boot_mirror && (ap == '0);
   end else begin : g_plain
      assign mirror_hit = 1'b0;
   end

   always_comb begin
      code = mirror_hit ? FIELD_W'(BOOT_CODE) : tbl_code;
      ofs  = mirror_hit ? '0 : tbl_ofs;
      dec_err   = (code == '0) || (code > FIELD_W'(MAX_CODE));
      slv_idx   = dec_err ? '0 : code;
      xlat_addr = {ofs, req_addr[LOW_W-1:0]};
   end

   AST_ERR_NO_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
      dec_err |-> (slv_idx == '0)); // R3
   AST_LOW_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      xlat_addr[LOW_W-1:0] == req_addr[LOW_W-1:0]); // R2
   if (BOOT_EN) begin : g_boot_chk
      AST_MIRROR_ROM: assert property (@(posedge clk) disable iff (!rst_n)
         (boot_mirror && ap == '0) |-> (slv_idx == FIELD_W'(BOOT_CODE)
                                        && xlat_addr[ADDR_W-1 -: AP_BITS] == '0)); // R8
   end
endmodule

// File: rtl/remap_ext.sv
module remap_ext #(
   parameter int unsigned EXT_W   = 4,
   parameter int unsigned EXT_RST = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_stage,
   input  logic             wr_commit,
   input  logic [EXT_W-1:0] wdata,
   output logic [EXT_W-1:0] stg_val,
   output logic [EXT_W-1:0] act_val
);
   logic commit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_val  <= EXT_W'(EXT_RST);
         act_val  <= EXT_W'(EXT_RST);
         commit_q <= 1'b0;
      end else begin
         if (wr_stage)  stg_val <= wdata;
         if (commit_q)  act_val <= stg_val;
         commit_q <= wr_commit;
      end
   end

   AST_EXT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_q |=> $stable(act_val)); // R9
endmodule

// File: rtl/aperture_remap_decoder.sv
module aperture_remap_decoder #(
   parameter int unsigned NUM_MASTERS = 12,
   parameter int unsigned NUM_AP      = 16,
   parameter int unsigned FIELD_W     = 4,
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned CFG_AW      = 12,
   parameter int unsigned MAX_CODE    = 10,
   parameter int unsigned BOOT_CODE   = 5,
   parameter int unsigned RST_CODE    = 1,
   parameter int unsigned BOOT_RST    = 1,
   parameter int unsigned EXT_W       = 4,
   parameter int unsigned EXT_RST     = 1,
   localparam int unsigned DW         = apr_pkg::CFG_WORD_W,
   localparam int unsigned TBL_W      = NUM_AP * FIELD_W,
   localparam int unsigned GRP_W      = CFG_AW - apr_pkg::GROUP_OFF_W
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_wr_en,
   input  logic [CFG_AW-1:0]             cfg_addr,
   input  logic [DW-1:0]                 cfg_wdata,
   output logic [DW-1:0]                 cfg_rdata,
   input  logic [NUM_MASTERS*ADDR_W-1:0] req_addr,
   output logic [NUM_MASTERS*FIELD_W-1:0] slv_idx,
   output logic [NUM_MASTERS*ADDR_W-1:0] xlat_addr,
   output logic [NUM_MASTERS-1:0]        dec_err,
   output logic [EXT_W-1:0]              ext_offset
);
   import apr_pkg::*;

   localparam logic [CFG_AW-1:0] EXT_ADDR = CFG_AW'(NUM_MASTERS * GROUP_BYTES);
   localparam logic [CFG_AW-1:0] EXT_UPD  = EXT_ADDR + CFG_AW'(OFF_COMMIT);

   if ((NUM_MASTERS + 1) * GROUP_BYTES > (1 << CFG_AW)) begin : g_bad_aw
      $error("aperture_remap_decoder: register space too small");
   end
   if (EXT_W > DW) begin : g_bad_ext
      $error("aperture_remap_decoder: extension field wider than a word");
   end

   logic [GRP_W-1:0]       grp;
   logic [GROUP_OFF_W-1:0] off;
   logic [1:0]             boot_q;
   logic [EXT_W-1:0]       ext_stg;
   logic [DW-1:0]          tbl_rd [NUM_MASTERS];

   assign grp = cfg_addr[CFG_AW-1:GROUP_OFF_W];
   assign off = cfg_addr[GROUP_OFF_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) boot_q <= 2'(BOOT_RST);
      else if (cfg_wr_en && grp == '0 && off == OFF_BOOT) boot_q <= cfg_wdata[1:0];
   end

   for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_master
      logic [TBL_W-1:0] act_sel, act_ofs;
      logic             grp_hit;

      assign grp_hit = (grp == GRP_W'(m));

      remap_table #(
         .NUM_AP(NUM_AP), .FIELD_W(FIELD_W), .RST_CODE(RST_CODE)
      ) u_tbl (
         .clk(clk), .rst_n(rst_n),
         .wr_en(cfg_wr_en && grp_hit), .wr_off(off), .wdata(cfg_wdata),
         .rd_off(off), .rd_data(tbl_rd[m]),
         .act_sel(act_sel), .act_ofs(act_ofs)
      );

      remap_lookup #(
         .NUM_AP(NUM_AP), .FIELD_W(FIELD_W), .ADDR_W(ADDR_W),
         .MAX_CODE(MAX_CODE), .BOOT_CODE(BOOT_CODE), .BOOT_EN(m == 0)
      ) u_look (
         .clk(clk), .rst_n(rst_n),
         .act_sel(act_sel), .act_ofs(act_ofs),
         .boot_mirror(|boot_q),
         .req_addr(req_addr[m*ADDR_W +: ADDR_W]),
         .slv_idx(slv_idx[m*FIELD_W +: FIELD_W]),
         .xlat_addr(xlat_addr[m*ADDR_W +: ADDR_W]),
         .dec_err(dec_err[m])
      );
   end

   remap_ext #(.EXT_W(EXT_W), .EXT_RST(EXT_RST)) u_ext (
      .clk(clk), .rst_n(rst_n),
      .wr_stage(cfg_wr_en && cfg_addr == EXT_ADDR),
      .wr_commit(cfg_wr_en && cfg_addr == EXT_UPD && cfg_wdata == DW'(1)),
      .wdata(cfg_wdata[EXT_W-1:0]),
      .stg_val(ext_stg), .act_val(ext_offset)
   );

   always_comb begin
      cfg_rdata = '0;
      for (int m = 0; m < int'(NUM_MASTERS); m++)
         if (grp == GRP_W'(m)) cfg_rdata = tbl_rd[m];
      if (grp == '0 && off == OFF_BOOT) cfg_rdata = {{(DW-2){1'b0}}, boot_q};
      if (cfg_addr == EXT_ADDR)         cfg_rdata = {{(DW-EXT_W){1'b0}}, ext_stg};
   end

   AST_BOOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_en && cfg_addr == CFG_AW'(OFF_BOOT)) |=> (boot_q == $past(cfg_wdata[1:0]))); // R8
endmodule

// File: tb/tb_aperture_remap_decoder.sv
module tb_aperture_remap_decoder;
   localparam int NM = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr_en = 1'b0;
   logic [11:0]   cfg_addr = '0;
   logic [31:0]   cfg_wdata = '0;
   logic [31:0]   cfg_rdata;
   logic [NM*32-1:0] req_addr = '0;
   logic [NM*4-1:0]  slv_idx;
   logic [NM*32-1:0] xlat_addr;
   logic [NM-1:0]    dec_err;
   logic [3:0]       ext_offset;

   int errors = 0;
   int checks = 0;

   logic [63:0] ms_sel [NM], ms_ofs [NM], ma_sel [NM], ma_ofs [NM];
   logic [NM-1:0] pend;
   logic [1:0]  mboot;
   logic [3:0]  ms_ext, ma_ext;
   logic        pend_ext;

   always #5 clk = ~clk;

   aperture_remap_decoder dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_addr(req_addr),
      .slv_idx(slv_idx), .xlat_addr(xlat_addr), .dec_err(dec_err),
      .ext_offset(ext_offset)
   );

   task automatic model_reset();
      for (int m = 0; m < NM; m++) begin
         ms_sel[m] = 64'h1111111111111111; ma_sel[m] = ms_sel[m];
         ms_ofs[m] = 64'hFEDCBA9876543210; ma_ofs[m] = ms_ofs[m];
      end
      pend = '0; mboot = 2'b01; ms_ext = 4'd1; ma_ext = 4'd1; pend_ext = 1'b0;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      int g;
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr_en = 1'b0;
      g = int'(a[11:5]);
      if (g < NM) begin
         case (a[4:0])
            5'h00: ms_sel[g][31:0]  = d;
            5'h04: ms_sel[g][63:32] = d;
            5'h08: ms_ofs[g][31:0]  = d;
            5'h0C: ms_ofs[g][63:32] = d;
            5'h10: if (g == 0) mboot = d[1:0];
            5'h14: if (d == 32'd1) pend[g] = 1'b1;
            default: ;
         endcase
      end
      if (a == 12'h180) ms_ext = d[3:0];
      if (a == 12'h194 && d == 32'd1) pend_ext = 1'b1;
   endtask

   task automatic settle();
      @(negedge clk);
      for (int m = 0; m < NM; m++)
         if (pend[m]) begin ma_sel[m] = ms_sel[m]; ma_ofs[m] = ms_ofs[m]; end
      if (pend_ext) ma_ext = ms_ext;
      pend = '0; pend_ext = 1'b0;
   endtask

   task automatic wr_s(input logic [11:0] a, input logic [31:0] d);
      wr(a, d);
      settle();
   endtask

   function automatic logic [36:0] expect_dec(input int m, input logic [31:0] a);
      logic [3:0] ap, code, ofs;
      logic err;
      ap   = a[31:28];
      code = ma_sel[m][int'(ap)*4 +: 4];
      ofs  = ma_ofs[m][int'(ap)*4 +: 4];
      if (m == 0 && mboot != 2'b00 && ap == 4'd0) begin code = 4'd5; ofs = 4'd0; end
      err = (code == 4'd0) || (code > 4'd10);
      return {err, err ? 4'd0 : code, ofs, a[27:0]};
   endfunction

   task automatic chk_dec(input string req, input logic [31:0] base, input bit rnd);
      logic [31:0] a [NM];
      for (int m = 0; m < NM; m++) begin
         a[m] = rnd ? $urandom : (base + 32'(m) * 32'h1000_0000);
         req_addr[m*32 +: 32] = a[m];
      end
      #1;
      for (int m = 0; m < NM; m++) begin
         logic [36:0] e, got;
         e = expect_dec(m, a[m]);
         got = {dec_err[m], slv_idx[m*4 +: 4], xlat_addr[m*32 +: 32]};
         checks++;
         if (got !== e) begin
            errors++;
            $display("FAIL %s master %0d addr %h: got err/slv/xlat %h expected %h",
                     req, m, a[m], got, e);
         end
      end
   endtask

   task automatic chk_rd(input string req, input logic [11:0] a, input logic [31:0] e);
      @(negedge clk);
      cfg_addr = a;
      #1;
      checks++;
      if (cfg_rdata !== e) begin
         errors++;
         $display("FAIL %s read %h: got %h expected %h", req, a, cfg_rdata, e);
      end
   endtask

   task automatic chk_ext(input string req);
      checks++;
      if (ext_offset !== ma_ext) begin
         errors++;
         $display("FAIL %s ext_offset: got %0d expected %0d", req, ext_offset, ma_ext);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd2024));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R7 reset state, including mirrored aperture 0 of master 0 (R8)
      chk_dec("R7", 32'h0000_0100, 1'b0);
      chk_rd("R7", 12'h000, 32'h11111111);
      chk_rd("R7", 12'h16C, 32'hFEDCBA98);
      chk_rd("R8", 12'h010, 32'h1);
      chk_ext("R9");

      // R1 R2 R3: new table on master 3, staged only (R5)
      wr_s(12'h060, 32'h7654_3210);
      wr_s(12'h064, 32'hFEDC_BA98);
      wr_s(12'h068, 32'h0123_4567);
      wr_s(12'h06C, 32'h89AB_CDEF);
      chk_dec("R5", 32'h0ABC_DEF0, 1'b0);
      chk_rd("R4", 12'h064, 32'hFEDC_BA98);
      chk_rd("R4", 12'h074, 32'h0);
      wr_s(12'h074, 32'd2);
      chk_dec("R5", 32'h0000_0040, 1'b0);

      // R6: commit timing, old just after the write edge, new one edge later
      wr(12'h074, 32'd1);
      #1;
      for (int k = 0; k < NM; k++) req_addr[k*32 +: 32] = 32'hA123_4567;
      #1;
      checks++;
      if (slv_idx[15:12] !== 4'd1 || xlat_addr[127:96] !== 32'hA123_4567) begin
         errors++;
         $display("FAIL R6 early: got slv %0d xlat %h expected 1 a1234567",
                  slv_idx[15:12], xlat_addr[127:96]);
      end
      settle();
      for (int s = 0; s < 16; s++) chk_dec("R1", 32'(s) << 28 | 32'h0055_AA00, 1'b0);
      chk_dec("R3", 32'hF000_0000, 1'b0);

      // R3: codes above the range on master 7 (R10 for the rest)
      wr_s(12'h0E4, 32'hFEDC_BA0A);
      wr_s(12'h0F4, 32'd1);
      for (int s = 8; s < 16; s++) chk_dec("R3", 32'(s) << 28, 1'b0);

      // R8: clear the mirror bits, master 0 aperture 0 now programmed
      wr_s(12'h000, 32'h1111_1113);
      wr_s(12'h014, 32'd1);
      chk_dec("R8", 32'h0000_0010, 1'b0);
      wr_s(12'h010, 32'h0);
      chk_dec("R8", 32'h0000_0010, 1'b0);
      chk_rd("R8", 12'h010, 32'h0);
      wr_s(12'h010, 32'h2);
      chk_dec("R8", 32'h0FFF_FFFF, 1'b0);

      // R9: extension register staged, then committed
      wr_s(12'h180, 32'h0);
      chk_ext("R9");
      chk_rd("R9", 12'h180, 32'h0);
      wr_s(12'h194, 32'd1);
      chk_ext("R9");

      // R4 R5 R10: random programming and decode
      for (int it = 0; it < 400; it++) begin
         logic [11:0] a;
         logic [31:0] d;
         int sel;
         sel = int'($urandom_range(0, 5));
         a = {7'($urandom_range(0, NM - 1)), 5'h00};
         case (sel)
            0: a[4:0] = 5'h00;
            1: a[4:0] = 5'h04;
            2: a[4:0] = 5'h08;
            3: a[4:0] = 5'h0C;
            default: a[4:0] = 5'h14;
         endcase
         d = $urandom;
         if (sel >= 4) d = ($urandom_range(0, 3) == 0) ? 32'd3 : 32'd1;
         wr_s(a, d);
         if (it % 4 == 0) begin
            int g;
            g = int'(a[11:5]);
            chk_rd("R4", {a[11:5], 5'h00}, ms_sel[g][31:0]);
            chk_rd("R4", {a[11:5], 5'h0C}, ms_ofs[g][63:32]);
         end
         chk_dec("R10", 32'h0, 1'b1);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule